// File: doc/BRIEF.md
# AC97 Link Frame Controller

This block is the controller end of a serial audio link in which the codec owns the bit clock. The controller counts bit-clock periods and drives a frame sync so that each 256-bit frame is split into 13 time slots. The first slot is a 16-bit tag and the other twelve carry 20-bit words. The outgoing frame is shifted onto the playback line, and the incoming frame is gathered from the capture line. The block also drives an active-low reset to the codec.

On the parallel side, the user presents one tag word and twelve slot words. The block takes a copy of them at the start of each frame. After the last capture bit of a frame, the block publishes the received tag and slots and pulses a single-cycle done strobe. The block implements only slot framing and bit timing. The meaning of the slot contents is left to the logic around it.

Top module: `ac97_link_ctrl`

## Requirements
- R1: `codec_rst_n` is low while `rst` is high. It goes high at the first rising bit-clock edge that samples `rst` low, and it stays high after that.
- R2: While `rst` is high, `sync` and `sdo` are held low, `frame_done` is low, and the bit position is cleared. The period after the first edge that samples `rst` low is therefore bit 0 of a new frame.
- R3: A frame is 256 bit periods long. `sync` is high during bit periods 0 to 15 (the tag slot) and low during bit periods 16 to 255.
- R4: `sdo` changes only after a rising edge. In bit period k it carries bit 255-k of the word `{tx_tag, tx_slots}`, so fields go out MSB first. Slot s (1..12) is `tx_slots[(12-s)*20+19 -: 20]`, which puts slot 1 in the top bits.
- R5: The transmit words are sampled only at the rising edge that starts bit period 0. A change to them during a frame appears on `sdo` from the next frame onward.
- R6: `sdi` is sampled on the falling edge inside each bit period. The bit taken in period k becomes bit 255-k of `{rx_tag, rx_slots}`, and the fields use the same layout as transmit.
- R7: `frame_done` is high for exactly one bit period. That period is bit 0 of the following frame, which is the period right after the last bit of slot 12. It is never high in two consecutive periods.
- R8: `rx_tag` and `rx_slots` change only at the edge that raises `frame_done`, and they hold their value otherwise. Reset clears them to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bit_clk | input | 1 | Bit clock supplied by the codec |
| rst | input | 1 | Synchronous active-high reset |
| sdi | input | 1 | Serial capture data from the codec |
| tx_tag | input | 16 | Tag word for the next transmitted frame |
| tx_slots | input | 240 | Twelve 20-bit transmit slot words, slot 1 in the top bits |
| codec_rst_n | output | 1 | Active-low reset to the codec |
| sync | output | 1 | Frame sync, high during the tag slot |
| sdo | output | 1 | Serial playback data to the codec |
| rx_tag | output | 16 | Tag word of the last complete received frame |
| rx_slots | output | 240 | Twelve 20-bit received slot words, slot 1 in the top bits |
| frame_done | output | 1 | One-period strobe when a received frame is published |

## Verification
The hardest case to reach from the ports is a reset that arrives partway through a frame. In that case the partial received frame must be discarded, the transmit shift must be dropped, and framing must restart cleanly at bit 0. The stimulus runs several full frames and then raises `rst` a little past the middle of a frame. After reset it checks that no stray strobe appears and that the first full frame after release lines up with the sync again. The transmit words are also changed in the middle of each frame. This shows that the change reaches `sdo` only from the next frame onward.

// File: rtl/ac97lnk_pkg.sv
package ac97lnk_pkg;

    localparam int TAG_BITS   = 16;
    localparam int SLOT_BITS  = 20;
    localparam int DATA_SLOTS = 12;

    // Status bundle published by the frame timer for the data paths
    typedef struct packed {
        logic run;   // link has left reset and is counting bits
        logic load;  // next rising edge begins bit period 0
        logic sync;  // registered frame sync level
    } tmr_stat_t;

    function automatic int frame_bits(input int tag_w, input int slot_w, input int n_slots);
        return tag_w + slot_w * n_slots;
    endfunction

endpackage

// File: rtl/lnk_frame_timer.sv
module lnk_frame_timer
    import ac97lnk_pkg::*;
#(
    parameter int TAG_W     = TAG_BITS,
    parameter int FRAME_LEN = 256
) (
    input  logic      clk,
    input  logic      rst,
    output tmr_stat_t stat
);
    localparam int CNT_W = $clog2(FRAME_LEN);

    logic [CNT_W-1:0] pos_q;
    logic             run_q;
    logic             sync_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pos_q  <= '0;
            run_q  <= 1'b0;
            sync_q <= 1'b0;
        end else begin
            run_q  <= 1'b1;
            sync_q <= (pos_q < CNT_W'(TAG_W));
            if (pos_q == CNT_W'(FRAME_LEN - 1))
                pos_q <= '0;
            else
                pos_q <= pos_q + 1'b1;
        end
    end

    assign stat.run  = run_q;
    assign stat.load = (pos_q == '0);
    assign stat.sync = sync_q;

    // Checker: count consecutive high sync periods independently of pos_q
    logic [CNT_W:0] hi_cnt;
    always_ff @(posedge clk) begin
        if (rst)
            hi_cnt <= '0;
        else if (sync_q)
            hi_cnt <= hi_cnt + 1'b1;
        else
            hi_cnt <= '0;
    end

    p_sync_len_r3: assert property (@(posedge clk) disable iff (rst)
        $fell(sync_q) |-> (hi_cnt == (CNT_W+1)'(TAG_W)));

endmodule

// File: rtl/lnk_tx_serializer.sv
module lnk_tx_serializer #(
    parameter int FRAME_LEN = 256
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 load,
    input  logic [FRAME_LEN-1:0] frame_word,
    output logic                 sdo
);
    logic [FRAME_LEN-1:0] shreg;

    always_ff @(posedge clk) begin
        if (rst) begin
            shreg <= '0;
            sdo   <= 1'b0;
        end else if (load) begin
            sdo   <= frame_word[FRAME_LEN-1];
            shreg <= {frame_word[FRAME_LEN-2:0], 1'b0};
        end else begin
            sdo   <= shreg[FRAME_LEN-1];
            shreg <= {shreg[FRAME_LEN-2:0], 1'b0};
        end
    end

endmodule

// File: rtl/lnk_rx_deserializer.sv
module lnk_rx_deserializer #(
    parameter int FRAME_LEN = 256
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 run,
    input  logic                 latch,
    input  logic                 sdi,
    output logic [FRAME_LEN-1:0] rx_word,
    output logic                 done
);
    logic [FRAME_LEN-1:0] shreg;

    // Capture on the falling edge, mid bit period
    always_ff @(negedge clk) begin
        if (run)
            shreg <= {shreg[FRAME_LEN-2:0], sdi};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rx_word <= '0;
            done    <= 1'b0;
        end else begin
            done <= latch;
            if (latch)
                rx_word <= shreg;
        end
    end

    p_done_pulse_r7: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

endmodule

// File: rtl/ac97_link_ctrl.sv
module ac97_link_ctrl
    import ac97lnk_pkg::*;
#(
    parameter int TAG_W   = TAG_BITS,
    parameter int SLOT_W  = SLOT_BITS,
    parameter int N_SLOTS = DATA_SLOTS
) (
    input  logic                      bit_clk,
    input  logic                      rst,
    input  logic                      sdi,
    input  logic [TAG_W-1:0]          tx_tag,
    input  logic [N_SLOTS*SLOT_W-1:0] tx_slots,
    output logic                      codec_rst_n,
    output logic                      sync,
    output logic                      sdo,
    output logic [TAG_W-1:0]          rx_tag,
    output logic [N_SLOTS*SLOT_W-1:0] rx_slots,
    output logic                      frame_done
);
    localparam int FRAME_LEN = frame_bits(TAG_W, SLOT_W, N_SLOTS);
    localparam int PAY_W     = N_SLOTS * SLOT_W;

    tmr_stat_t            stat;
    logic [FRAME_LEN-1:0] rx_word;
    logic                 codec_rst_q;

    always_ff @(posedge bit_clk) begin
        if (rst) codec_rst_q <= 1'b0;
        else     codec_rst_q <= 1'b1;
    end
    assign codec_rst_n = codec_rst_q;

    lnk_frame_timer #(.TAG_W(TAG_W), .FRAME_LEN(FRAME_LEN)) timer_i (
        .clk (bit_clk),
        .rst (rst),
        .stat(stat)
    );

    lnk_tx_serializer #(.FRAME_LEN(FRAME_LEN)) tx_i (
        .clk       (bit_clk),
        .rst       (rst),
        .load      (stat.load),
        .frame_word({tx_tag, tx_slots}),
        .sdo       (sdo)
    );

    lnk_rx_deserializer #(.FRAME_LEN(FRAME_LEN)) rx_i (
        .clk    (bit_clk),
        .rst    (rst),
        .run    (stat.run),
        .latch  (stat.run && stat.load),
        .sdi    (sdi),
        .rx_word(rx_word),
        .done   (frame_done)
    );

    assign sync     = stat.sync;
    assign rx_tag   = rx_word[FRAME_LEN-1 -: TAG_W];
    assign rx_slots = rx_word[PAY_W-1:0];

    p_reset_quiet_r2: assert property (@(posedge bit_clk) disable iff (rst)
        $fell(rst) |-> (!sync && !sdo && !frame_done && !codec_rst_n));

    p_codec_up_r1: assert property (@(posedge bit_clk) disable iff (rst)
        $fell(rst) |=> codec_rst_n);

    p_done_in_tag_r7: assert property (@(posedge bit_clk) disable iff (rst)
        frame_done |-> sync);

    p_rx_hold_r8: assert property (@(posedge bit_clk) disable iff (rst)
        (!$stable(rx_tag) && !$past(rst)) |-> frame_done);

endmodule

// File: tb/ac97_link_ctrl_tb.sv
module ac97_link_ctrl_tb_top;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         sdi = 1'b0;
    logic [15:0]  tx_tag;
    logic [239:0] tx_slots;
    logic         codec_rst_n, sync, sdo, frame_done;
    logic [15:0]  rx_tag;
    logic [239:0] rx_slots;

    int checks = 0;
    int failures = 0;
    int n = 0;
    int rx_frame_no = 0;
    logic [255:0] exp_tx, cur_rx, exp_rx;
    bit done_exp;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    ac97_link_ctrl dut_i (
        .bit_clk(clk), .rst(rst), .sdi(sdi), .tx_tag(tx_tag), .tx_slots(tx_slots),
        .codec_rst_n(codec_rst_n), .sync(sync), .sdo(sdo), .rx_tag(rx_tag),
        .rx_slots(rx_slots), .frame_done(frame_done)
    );

    task automatic chk(input bit ok, input string req, input logic [255:0] act, input logic [255:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s at t=%0t n=%0d: actual=%h expected=%h", req, $time, n, act, exp);
        end
    endtask

    task automatic set_tx(input int pat);
        case (pat % 4)
            0: begin tx_tag = '0; tx_slots = '0; end
            1: begin tx_tag = '1; tx_slots = '1; end
            2: begin tx_tag = 16'hA5C3; tx_slots = {12{20'hA_AAAA}}; end
            default: begin
                tx_tag = 16'($urandom);
                for (int i = 0; i < 8; i++) tx_slots[i*30 +: 30] = 30'($urandom);
            end
        endcase
    endtask

    task automatic new_rx();
        for (int i = 0; i < 8; i++) cur_rx[i*32 +: 32] = $urandom;
        if (rx_frame_no % 3 == 2) cur_rx = '1;
        rx_frame_no++;
    endtask

    task automatic do_reset(input int cyc);
        rst = 1'b1;
        for (int i = 0; i < cyc; i++) begin
            @(posedge clk);
            #1;
            sdi = 1'b0;
            if (i == cyc - 1) rst = 1'b0;
            #1;
            chk(sync == 1'b0, "R2 sync low in reset", 256'(sync), 256'(0));
            chk(sdo == 1'b0, "R2 sdo low in reset", 256'(sdo), 256'(0));
            chk(frame_done == 1'b0, "R2 no strobe in reset", 256'(frame_done), 256'(0));
            chk(codec_rst_n == 1'b0, "R1 codec reset low", 256'(codec_rst_n), 256'(0));
            chk(rx_tag == 16'h0 && rx_slots == 240'h0, "R8 rx cleared by reset",
                {rx_tag, rx_slots}, 256'(0));
        end
        n = 0;
        exp_rx = '0;
    endtask

    task automatic run_cycles(input int cyc);
        for (int c = 0; c < cyc; c++) begin
            int k;
            @(posedge clk);
            k = n % 256;
            done_exp = 1'b0;
            if (k == 0) begin
                exp_tx = {tx_tag, tx_slots};
                if (n >= 256) begin
                    exp_rx = cur_rx;
                    done_exp = 1'b1;
                end
                new_rx();
            end
            #1;
            sdi = cur_rx[255 - k];
            if (k == 100) set_tx(n / 256 + 1);
            #1;
            chk(codec_rst_n == 1'b1, "R1 codec reset released", 256'(codec_rst_n), 256'(1));
            chk(sync == (k < 16), (n < 256) ? "R2 first frame aligned" : "R3 sync shape",
                256'(sync), 256'(k < 16));
            chk(sdo == exp_tx[255 - k], (n >= 256 && k > 100) ? "R5 tx sampled at frame start" : "R4 sdo bit",
                256'(sdo), 256'(exp_tx[255 - k]));
            chk(frame_done == done_exp, "R7 frame_done timing", 256'(frame_done), 256'(done_exp));
            chk({rx_tag, rx_slots} == exp_rx, done_exp ? "R6 rx frame contents" : "R8 rx hold",
                {rx_tag, rx_slots}, exp_rx);
            n++;
        end
    endtask

    initial begin
        #(200000 * 8);
        if (!finished) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        cur_rx = '0;
        exp_rx = '0;
        exp_tx = '0;
        set_tx(3);
        do_reset(4);
        run_cycles(3 * 256 + 140);
        do_reset(5);
        run_cycles(3 * 256 + 20);
        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule